// File: doc/BRIEF.md
# Trap and Interrupt Context Unit

This unit performs the control transfers for a subroutine call, a subroutine return, a system call, a software interrupt and an interrupt return. It keeps three save registers. The first save register holds a saved instruction pointer. The second holds a saved stack pointer. The third holds a saved flag word.

A command arrives as a one-cycle strobe together with a command code, a vector number and a privilege bit. The unit samples the current IP, SP and flag values, then returns the next values on its outputs with load strobes. Interrupt and system call entry fetch the handler address from an external descriptor table through a request/index port. The table answers one cycle later.

All results appear in the cycle after the command strobe. While a table read is outstanding, the unit reports busy and ignores new commands. The software interrupt and interrupt return are privileged. When either arrives in user mode, the unit raises a fault and changes nothing.

Top module: `trap_ctx_unit`

## Requirements
- R1: After reset, ld_ip_o, ld_sp_o, ld_flg_o, busy_o, fault_o and tbl_req_o are all 0, and all three save registers are 0.
- R2: Command code 0 (call) copies cur_ip_i into the IP save register. In the next cycle it asserts ld_ip_o with new_ip_o equal to the sampled tgt_i, and ld_sp_o and ld_flg_o stay 0.
- R3: Command code 1 (return) asserts ld_ip_o in the next cycle, with new_ip_o equal to the IP save register.
- R4: Command code 3 (software interrupt) in privileged mode saves IP, SP and flags. It asserts tbl_req_o in the same cycle with tbl_idx_o equal to cmd_vec_i. In the next cycle it asserts ld_ip_o, ld_sp_o and ld_flg_o, with new_ip_o = tbl_data_i, new_sp_o = the sampled SP, and new_flg_o = the sampled flags with bits 16 and 17 cleared.
- R5: Command code 2 (system call) behaves like R4 but always reads table entry 6, whatever cmd_vec_i holds, and it is allowed in user mode.
- R6: Command code 4 (interrupt return) in privileged mode asserts ld_ip_o, ld_sp_o and ld_flg_o in the next cycle, with values taken from the three save registers.
- R7: Command codes 3 and 4 with priv_i=0 pulse fault_o in the next cycle. They assert no load strobe and no table request, and the save registers keep their values.
- R8: busy_o is high in the cycle after a table request. A command strobed in that cycle is ignored: it produces no strobe and no fault, and it does not touch the save registers.
- R9: Command codes 5 to 7 are ignored. They produce no strobe, no fault and no table request, and the save registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_vec_i | input | VEC_W | Interrupt vector |
| priv_i | input | 1 | 1 = privileged mode |
| tgt_i | input | XLEN | Call target address |
| cur_ip_i | input | XLEN | Current instruction pointer |
| cur_sp_i | input | XLEN | Current stack pointer |
| cur_flg_i | input | XLEN | Current flag word |
| tbl_req_o | output | 1 | Descriptor table read request |
| tbl_idx_o | output | VEC_W | Descriptor table index |
| tbl_data_i | input | XLEN | Table data, valid the cycle after the request |
| ld_ip_o | output | 1 | Load strobe for new_ip_o |
| new_ip_o | output | XLEN | Next instruction pointer |
| ld_sp_o | output | 1 | Load strobe for new_sp_o |
| new_sp_o | output | XLEN | Next stack pointer |
| ld_flg_o | output | 1 | Load strobe for new_flg_o |
| new_flg_o | output | XLEN | Next flag word |
| busy_o | output | 1 | Table read pending |
| fault_o | output | 1 | Privilege fault pulse |

## Verification
The bench strobes an interrupt with an all-ones flag word. A design that clears the wrong bits, or clears none, returns a different flag word on entry. A system call is issued in user mode with a nonzero vector. A unit that uses the given vector, or that faults the call, loads the wrong handler address. A call is also strobed in the busy cycle, and a design that accepts it overwrites the saved IP, which the following return exposes. User-mode interrupts and undefined codes are each followed by a privileged interrupt return. Any save register that the ignored command disturbed then shows up in the restored values.

// File: rtl/trap_ctx_pkg.sv
package trap_ctx_pkg;
  typedef enum logic [2:0] {
    OP_CALL  = 3'd0,
    OP_RET   = 3'd1,
    OP_SCALL = 3'd2,
    OP_INT   = 3'd3,
    OP_IRET  = 3'd4
  } trap_op_e;

  typedef struct packed {
    logic save_ip;
    logic save_all;
    logic use_tgt;
    logic rest_ip;
    logic rest_all;
    logic tbl_rd;
    logic sys;
    logic fault;
  } trap_act_t;
endpackage

// File: rtl/trap_decode.sv
module trap_decode
  import trap_ctx_pkg::*;
(
  input  logic      valid_i,
  input  logic      busy_i,
  input  logic [2:0] op_i,
  input  logic      priv_i,
  output trap_act_t act_o
);
  logic take;
  assign take = valid_i & ~busy_i;

  always_comb begin
    act_o = '0;
    if (take) begin
      unique case (op_i)
        OP_CALL: begin
          act_o.save_ip = 1'b1;
          act_o.use_tgt = 1'b1;
        end
        OP_RET:   act_o.rest_ip = 1'b1;
        OP_SCALL: begin
          act_o.save_all = 1'b1;
          act_o.tbl_rd   = 1'b1;
          act_o.sys      = 1'b1;
        end
        OP_INT: begin
          if (priv_i) begin
            act_o.save_all = 1'b1;
            act_o.tbl_rd   = 1'b1;
          end else begin
            act_o.fault = 1'b1;
          end
        end
        OP_IRET: begin
          if (priv_i) act_o.rest_all = 1'b1;
          else        act_o.fault    = 1'b1;
        end
        default: act_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/trap_save_regs.sv
module trap_save_regs #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            save_ip_i,
  input  logic            save_all_i,
  input  logic [XLEN-1:0] ip_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] flg_i,
  output logic [XLEN-1:0] cs_ip_o,
  output logic [XLEN-1:0] cs_sp_o,
  output logic [XLEN-1:0] cs_flg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_ip_o  <= '0;
      cs_sp_o  <= '0;
      cs_flg_o <= '0;
    end else begin
      if (save_ip_i || save_all_i) cs_ip_o <= ip_i;
      if (save_all_i) begin
        cs_sp_o  <= sp_i;
        cs_flg_o <= flg_i;
      end
    end
  end
endmodule

// File: rtl/trap_out_stage.sv
module trap_out_stage
  import trap_ctx_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] CLR_MASK = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  trap_act_t       act_i,
  input  logic [XLEN-1:0] tgt_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] flg_i,
  input  logic [XLEN-1:0] cs_ip_i,
  input  logic [XLEN-1:0] cs_sp_i,
  input  logic [XLEN-1:0] cs_flg_i,
  input  logic [XLEN-1:0] tbl_data_i,
  output logic            ld_ip_o,
  output logic [XLEN-1:0] new_ip_o,
  output logic            ld_sp_o,
  output logic [XLEN-1:0] new_sp_o,
  output logic            ld_flg_o,
  output logic [XLEN-1:0] new_flg_o,
  output logic            pend_o,
  output logic            fault_o
);
  logic            ld_ip_q, pend_q, ld_ctx_q, fault_q;
  logic [XLEN-1:0] ip_q, sp_q, flg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_ip_q  <= 1'b0;
      pend_q   <= 1'b0;
      ld_ctx_q <= 1'b0;
      fault_q  <= 1'b0;
      ip_q     <= '0;
      sp_q     <= '0;
      flg_q    <= '0;
    end else begin
      ld_ip_q  <= act_i.use_tgt | act_i.rest_ip | act_i.rest_all;
      pend_q   <= act_i.tbl_rd;
      ld_ctx_q <= act_i.tbl_rd | act_i.rest_all;
      fault_q  <= act_i.fault;
      ip_q     <= act_i.use_tgt ? tgt_i : cs_ip_i;
      sp_q     <= act_i.rest_all ? cs_sp_i : sp_i;
      flg_q    <= act_i.rest_all ? cs_flg_i : (flg_i & ~CLR_MASK);
    end
  end

  // table data arrives one cycle after the request
  assign ld_ip_o   = ld_ip_q | pend_q;
  assign new_ip_o  = pend_q ? tbl_data_i : ip_q;
  assign ld_sp_o   = ld_ctx_q;
  assign ld_flg_o  = ld_ctx_q;
  assign new_sp_o  = sp_q;
  assign new_flg_o = flg_q;
  assign pend_o    = pend_q;
  assign fault_o   = fault_q;
endmodule

// File: rtl/trap_ctx_unit.sv
module trap_ctx_unit
  import trap_ctx_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int VEC_W   = 4,
  parameter int SYS_VEC = 6,
  parameter int CLR_LO  = 16,
  parameter int CLR_N   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [VEC_W-1:0] cmd_vec_i,
  input  logic             priv_i,
  input  logic [XLEN-1:0]  tgt_i,
  input  logic [XLEN-1:0]  cur_ip_i,
  input  logic [XLEN-1:0]  cur_sp_i,
  input  logic [XLEN-1:0]  cur_flg_i,
  output logic             tbl_req_o,
  output logic [VEC_W-1:0] tbl_idx_o,
  input  logic [XLEN-1:0]  tbl_data_i,
  output logic             ld_ip_o,
  output logic [XLEN-1:0]  new_ip_o,
  output logic             ld_sp_o,
  output logic [XLEN-1:0]  new_sp_o,
  output logic             ld_flg_o,
  output logic [XLEN-1:0]  new_flg_o,
  output logic             busy_o,
  output logic             fault_o
);
  localparam logic [XLEN-1:0]  ClrMask = ((XLEN'(1) << CLR_N) - XLEN'(1)) << CLR_LO;
  localparam logic [VEC_W-1:0] SysIdx  = VEC_W'(SYS_VEC);

  trap_act_t       act;
  logic            pend;
  logic [XLEN-1:0] cs_ip, cs_sp, cs_flg;

  trap_decode u_dec (
    .valid_i (cmd_valid_i),
    .busy_i  (pend),
    .op_i    (cmd_op_i),
    .priv_i  (priv_i),
    .act_o   (act)
  );

  trap_save_regs #(.XLEN(XLEN)) u_save (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .save_ip_i  (act.save_ip),
    .save_all_i (act.save_all),
    .ip_i       (cur_ip_i),
    .sp_i       (cur_sp_i),
    .flg_i      (cur_flg_i),
    .cs_ip_o    (cs_ip),
    .cs_sp_o    (cs_sp),
    .cs_flg_o   (cs_flg)
  );

  trap_out_stage #(.XLEN(XLEN), .CLR_MASK(ClrMask)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .tgt_i      (tgt_i),
    .sp_i       (cur_sp_i),
    .flg_i      (cur_flg_i),
    .cs_ip_i    (cs_ip),
    .cs_sp_i    (cs_sp),
    .cs_flg_i   (cs_flg),
    .tbl_data_i (tbl_data_i),
    .ld_ip_o    (ld_ip_o),
    .new_ip_o   (new_ip_o),
    .ld_sp_o    (ld_sp_o),
    .new_sp_o   (new_sp_o),
    .ld_flg_o   (ld_flg_o),
    .new_flg_o  (new_flg_o),
    .pend_o     (pend),
    .fault_o    (fault_o)
  );

  assign tbl_req_o = act.tbl_rd;
  assign tbl_idx_o = act.sys ? SysIdx : cmd_vec_i;
  assign busy_o    = pend;
endmodule

// File: rtl/trap_ctx_chk.sv
module trap_ctx_chk #(
  parameter int VEC_W   = 4,
  parameter int SYS_VEC = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [2:0]       cmd_op_i,
  input logic             priv_i,
  input logic             tbl_req_o,
  input logic [VEC_W-1:0] tbl_idx_o,
  input logic             ld_ip_o,
  input logic             ld_sp_o,
  input logic             ld_flg_o,
  input logic             busy_o,
  input logic             fault_o
);
  // R8
  busy_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_req_o |=> busy_o);
  // R8
  no_req_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !tbl_req_o);
  // R7
  fault_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!ld_ip_o && !ld_sp_o && !ld_flg_o));
  // R7
  user_int_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && !priv_i && (cmd_op_i == 3'd3 || cmd_op_i == 3'd4)) |=> fault_o);
  // R5
  sys_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_req_o && cmd_op_i == 3'd2) |-> (tbl_idx_o == VEC_W'(SYS_VEC)));
  // R4
  ctx_load_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_sp_o |-> (ld_flg_o && ld_ip_o));
  // R9
  undef_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i > 3'd4) |=> (!ld_ip_o && !fault_o));
endmodule

bind trap_ctx_unit trap_ctx_chk #(.VEC_W(VEC_W), .SYS_VEC(SYS_VEC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .priv_i      (priv_i),
  .tbl_req_o   (tbl_req_o),
  .tbl_idx_o   (tbl_idx_o),
  .ld_ip_o     (ld_ip_o),
  .ld_sp_o     (ld_sp_o),
  .ld_flg_o    (ld_flg_o),
  .busy_o      (busy_o),
  .fault_o     (fault_o)
);

// File: tb/test_trap_ctx_unit.sv
module test_trap_ctx_unit;
  localparam int XLEN = 32;
  localparam int VEC_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cmd_valid_i = 1'b0;
  logic [2:0]       cmd_op_i = '0;
  logic [VEC_W-1:0] cmd_vec_i = '0;
  logic             priv_i = 1'b0;
  logic [XLEN-1:0]  tgt_i = '0, cur_ip_i = '0, cur_sp_i = '0, cur_flg_i = '0;
  logic             tbl_req_o;
  logic [VEC_W-1:0] tbl_idx_o;
  logic [XLEN-1:0]  tbl_data_i = '0;
  logic             ld_ip_o, ld_sp_o, ld_flg_o, busy_o, fault_o;
  logic [XLEN-1:0]  new_ip_o, new_sp_o, new_flg_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  trap_ctx_unit i_trap_ctx_unit (.*);

  function automatic logic [XLEN-1:0] tbl_val(logic [VEC_W-1:0] idx);
    return 32'hA000_0000 + 32'(idx) * 32'h40;
  endfunction

  // table model: one-cycle read
  always @(posedge clk_i) if (tbl_req_o) tbl_data_i <= tbl_val(tbl_idx_o);

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on negedge, outputs of the command visible at the next negedge
  task automatic issue(logic [2:0] op, logic [VEC_W-1:0] vec, logic pr,
                       logic [XLEN-1:0] tgt, logic [XLEN-1:0] ip,
                       logic [XLEN-1:0] sp, logic [XLEN-1:0] flg);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_vec_i = vec; priv_i = pr;
    tgt_i = tgt; cur_ip_i = ip; cur_sp_i = sp; cur_flg_i = flg;
    #1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic idle;
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk("R1 ld_ip", 32'(ld_ip_o), 0);
    chk("R1 ld_sp", 32'(ld_sp_o | ld_flg_o), 0);
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 fault", 32'(fault_o), 0);
    chk("R1 tbl_req", 32'(tbl_req_o), 0);
    issue(3'd4, 0, 1'b1, 0, 0, 0, 0);
    chk("R1 save ip zero", new_ip_o, 0);
    chk("R1 save sp zero", new_sp_o, 0);
    chk("R1 save flg zero", new_flg_o, 0);
    idle();
  endtask

  task automatic t_call_ret;
    issue(3'd0, 0, 1'b0, 32'h0000_2000, 32'h0000_1234, 32'h55, 32'h1);
    chk("R2 ld_ip", 32'(ld_ip_o), 1);
    chk("R2 target", new_ip_o, 32'h0000_2000);
    chk("R2 no ctx load", 32'(ld_sp_o | ld_flg_o), 0);
    idle();
    issue(3'd1, 0, 1'b0, 32'hDEAD, 32'h0000_2010, 0, 0);
    chk("R3 ld_ip", 32'(ld_ip_o), 1);
    chk("R3 return ip", new_ip_o, 32'h0000_1234);
    idle();
  endtask

  task automatic t_int_iret;
    cmd_valid_i = 1'b1; cmd_op_i = 3'd3; cmd_vec_i = 4'd3; priv_i = 1'b1;
    cur_ip_i = 32'h0000_3000; cur_sp_i = 32'h0000_8000; cur_flg_i = 32'hFFFF_FFFF;
    #1;
    chk("R4 tbl_req", 32'(tbl_req_o), 1);
    chk("R4 tbl_idx", 32'(tbl_idx_o), 3);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk("R4 ld all", 32'({ld_ip_o, ld_sp_o, ld_flg_o}), 7);
    chk("R4 handler", new_ip_o, tbl_val(4'd3));
    chk("R4 sp", new_sp_o, 32'h0000_8000);
    chk("R4 flg cleared", new_flg_o, 32'hFFFC_FFFF);
    idle();
    issue(3'd4, 0, 1'b1, 0, 32'h9999, 32'h7777, 32'h0);
    chk("R6 ld all", 32'({ld_ip_o, ld_sp_o, ld_flg_o}), 7);
    chk("R6 ip", new_ip_o, 32'h0000_3000);
    chk("R6 sp", new_sp_o, 32'h0000_8000);
    chk("R6 flg", new_flg_o, 32'hFFFF_FFFF);
    idle();
  endtask

  task automatic t_scall;
    cmd_valid_i = 1'b1; cmd_op_i = 3'd2; cmd_vec_i = 4'd9; priv_i = 1'b0;
    cur_ip_i = 32'h0000_4444; cur_sp_i = 32'h0000_6000; cur_flg_i = 32'h0003_0005;
    #1;
    chk("R5 tbl_idx", 32'(tbl_idx_o), 6);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk("R5 no fault", 32'(fault_o), 0);
    chk("R5 handler", new_ip_o, tbl_val(4'd6));
    chk("R5 flg", new_flg_o, 32'h0000_0005);
    idle();
  endtask

  task automatic t_busy;
    issue(3'd3, 4'd1, 1'b1, 0, 32'h0000_5000, 32'h0000_5100, 32'h10);
    chk("R8 busy", 32'(busy_o), 1);
    issue(3'd0, 0, 1'b1, 32'hBAD0, 32'h0000_5555, 0, 0);
    chk("R8 ignored ld", 32'(ld_ip_o), 0);
    chk("R8 ignored fault", 32'(fault_o), 0);
    idle();
    issue(3'd1, 0, 1'b1, 0, 0, 0, 0);
    chk("R8 save kept", new_ip_o, 32'h0000_5000);
    idle();
  endtask

  task automatic t_priv;
    issue(3'd3, 4'd2, 1'b0, 0, 32'hEEEE, 32'hEEEE, 32'hEEEE);
    chk("R7 int fault", 32'(fault_o), 1);
    chk("R7 int no ld", 32'({ld_ip_o, ld_sp_o, ld_flg_o}), 0);
    idle();
    issue(3'd4, 0, 1'b0, 0, 0, 0, 0);
    chk("R7 iret fault", 32'(fault_o), 1);
    chk("R7 iret no ld", 32'(ld_ip_o), 0);
    idle();
    issue(3'd4, 0, 1'b1, 0, 0, 0, 0);
    chk("R7 ip kept", new_ip_o, 32'h0000_5000);
    chk("R7 sp kept", new_sp_o, 32'h0000_5100);
    idle();
  endtask

  task automatic t_undef;
    for (int k = 5; k < 8; k++) begin
      issue(3'(k), 4'd7, 1'b1, 32'h1, 32'h2, 32'h3, 32'h4);
      chk("R9 no strobe", 32'({ld_ip_o, ld_sp_o, fault_o, busy_o}), 0);
      idle();
    end
    issue(3'd4, 0, 1'b1, 0, 0, 0, 0);
    chk("R9 flg kept", new_flg_o, 32'h10);
    chk("R9 ip kept", new_ip_o, 32'h0000_5000);
    idle();
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_call_ret();
    t_int_iret();
    t_scall();
    t_busy();
    t_priv();
    t_undef();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule